// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is a write-back data cache with two ways per set and byte-wide access on the processor side. It holds 1024 eight-byte blocks as 512 sets of two ways. The tags of both ways in the addressed set are compared at once, and the hitting way's block goes through a multiplexer to a byte selector. One bit per set records which way was used least recently.

A miss chooses a victim. An empty way wins, and way 0 wins when both ways are empty. Otherwise the way named by the set's recency bit is evicted. A modified victim goes to memory as a whole block before the missing block is fetched. The fetched block then replaces the victim's tag, valid bit and data. Writes allocate on a miss. The requester sees one outstanding access at a time: a request is taken only while `ready` is high, and each access ends with a one-cycle `respValid` pulse. The memory side uses a request that is held until a one-cycle acknowledge.

Top module: `tw_cache_top`

## Requirements
- R1: An address splits into tag = addr[31:12], set = addr[11:3] and byte offset = addr[2:0]. Every memory transfer carries the block address, meaning the tag followed by the set (addr[31:3]).
- R2: An access hits when either way of the addressed set is valid and holds an equal tag. A hit raises `respValid` in the cycle after acceptance and makes no memory transfer. At most one way ever hits.
- R3: A read returns byte k of the block on `respData`, where k is the byte offset and byte k sits at bits [8k+7:8k] of a block.
- R4: After a hit or a fill, the set's recency bit names the other way, so the next victim in a full set is the way not touched last.
- R5: On a miss, an invalid way is filled first, with way 0 chosen when both are invalid. When both ways are valid, the way named by the recency bit (0 = way 0, 1 = way 1) is evicted.
- R6: A valid, modified victim is written to memory (`memWrite`=1, victim tag and set, its 64-bit block) before the refill read starts. With an acknowledge delay of three cycles, such a miss answers 8 cycles after acceptance.
- R7: A clean or invalid victim causes only the refill read, and the miss answers 4 cycles after acceptance with the same memory delay.
- R8: A write hit, or a write miss after its fill, stores the byte at its offset, marks the way modified and echoes the written byte on `respData`. The other bytes of a filled block come from memory.
- R9: Reset clears every valid, modified and recency bit. After reset `ready`=1, `respValid`=0 and `memReq`=0, and the first access to any block misses with no write-back.
- R10: While a miss is in progress `ready` is low, and requests presented then are ignored: they neither allocate nor write.
- R11: Once raised, `memReq` stays high with a stable `memAddr` and `memWrite` until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Access request, taken while `ready` is high |
| reqWrite | input | 1 | 1 = byte write, 0 = byte read |
| reqAddr | input | 32 | Byte address |
| reqWData | input | 8 | Write byte |
| ready | output | 1 | Cache can accept a request this cycle |
| respValid | output | 1 | One-cycle pulse that ends an access |
| respData | output | 8 | Read byte, or echoed write byte |
| memReq | output | 1 | Memory transfer request |
| memWrite | output | 1 | 1 = write-back, 0 = refill read |
| memAddr | output | 29 | Block address (tag, set) |
| memWData | output | 64 | Victim block being written back |
| memAck | input | 1 | One-cycle transfer acknowledge |
| memRData | input | 64 | Refill block, valid with `memAck` |

## Verification
A wrong tag, valid or recency bit does not stay hidden. It shows up at the next access to the same set. A lost hit turns a 1-cycle answer into a 4- or 8-cycle one with an extra refill at the memory port. A wrong victim choice writes back the wrong block address, or evicts a block the bench then finds missing. A lost modified bit drops a write-back, and the stale byte comes back from memory on the following read of that block.

// File: rtl/tw_cache_pkg.sv
package tw_cache_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic lookup;   // idle: index with the live request address
    logic latch;    // capture the accepted request
    logic hitUpd;   // hit: update recency, merge write byte
    logic fill;     // refill data arrived: install the block in the victim way
    logic wbSel;    // memory address points at the victim block
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2
  } ctlState_t;

endpackage

// File: rtl/tw_cache_dpath.sv
module tw_cache_dpath
  import tw_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 9,
  parameter int OFF_W  = 3,
  parameter int BYTE_W = 8,
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
  localparam int BLK_W  = BYTE_W << OFF_W,
  localparam int BADR_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0] reqWData,
  input  logic [BLK_W-1:0]  memRData,
  output logic              lookupHit,
  output logic              victimDirty,
  output logic [BYTE_W-1:0] respData,
  output logic [BADR_W-1:0] memAddr,
  output logic [BLK_W-1:0]  memWData
);

  localparam int NUM_SETS = 1 << SET_W;
  localparam int WAYS     = 2;

  // accepted request, held for the duration of a miss
  logic [ADDR_W-1:0] curAddr;
  logic              curWrite;
  logic [BYTE_W-1:0] curWData;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr  <= '0;
      curWrite <= 1'b0;
      curWData <= '0;
    end else if (stb.latch) begin
      curAddr  <= reqAddr;
      curWrite <= reqWrite;
      curWData <= reqWData;
    end
  end

  logic [ADDR_W-1:0] selAddr;
  logic [TAG_W-1:0]  selTag;
  logic [SET_W-1:0]  selSet;
  logic [OFF_W-1:0]  selOff;
  logic              effWrite;
  logic [BYTE_W-1:0] effWData;

  always_comb begin
    selAddr  = stb.lookup ? reqAddr  : curAddr;
    effWrite = stb.lookup ? reqWrite : curWrite;
    effWData = stb.lookup ? reqWData : curWData;
    selTag   = selAddr[ADDR_W-1 -: TAG_W];
    selSet   = selAddr[OFF_W +: SET_W];
    selOff   = selAddr[OFF_W-1:0];
  end

  function automatic logic [BLK_W-1:0] putByte(input logic [BLK_W-1:0]  blk,
                                                input logic [OFF_W-1:0]  off,
                                                input logic [BYTE_W-1:0] val);
    logic [BLK_W-1:0] r;
    r = blk;
    r[off*BYTE_W +: BYTE_W] = val;
    return r;
  endfunction

  // per-way read ports at the selected set
  logic [WAYS-1:0]   wayValid;
  logic [WAYS-1:0]   wayDirty;
  logic [WAYS-1:0]   hitVec;
  logic [TAG_W-1:0]  wayTag  [WAYS];
  logic [BLK_W-1:0]  wayData [WAYS];

  logic              hitWay;
  logic              victimWay;
  logic [BLK_W-1:0]  hitBlk;
  logic [BLK_W-1:0]  mergedHit;
  logic [BLK_W-1:0]  fillBlk;
  logic [NUM_SETS-1:0] lruQ;

  generate
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
      logic [NUM_SETS-1:0] validQ;
      logic [NUM_SETS-1:0] dirtyQ;
      logic [TAG_W-1:0]    tagQ  [NUM_SETS];
      logic [BLK_W-1:0]    dataQ [NUM_SETS];
      logic                wrHit;
      logic                wrFill;

      assign wayValid[gw] = validQ[selSet];
      assign wayDirty[gw] = dirtyQ[selSet];
      assign wayTag[gw]   = tagQ[selSet];
      assign wayData[gw]  = dataQ[selSet];
      assign hitVec[gw]   = validQ[selSet] && (tagQ[selSet] == selTag);
      assign wrHit        = stb.hitUpd && hitVec[gw];
      assign wrFill       = stb.fill && (victimWay == 1'(gw));

      always_ff @(posedge clk) begin
        if (rst) begin
          validQ <= '0;
          dirtyQ <= '0;
        end else if (wrFill) begin
          validQ[selSet] <= 1'b1;
          dirtyQ[selSet] <= curWrite;
        end else if (wrHit && effWrite) begin
          dirtyQ[selSet] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (wrFill) begin
          tagQ[selSet]  <= selTag;
          dataQ[selSet] <= fillBlk;
        end else if (wrHit && effWrite) begin
          dataQ[selSet] <= mergedHit;
        end
      end
    end
  endgenerate

  always_comb begin
    lookupHit = |hitVec;
    hitWay    = hitVec[1];
    hitBlk    = wayData[hitWay];
    mergedHit = putByte(hitBlk, selOff, effWData);
    fillBlk   = curWrite ? putByte(memRData, selOff, curWData) : memRData;
    if (!wayValid[0])      victimWay = 1'b0;
    else if (!wayValid[1]) victimWay = 1'b1;
    else                   victimWay = lruQ[selSet];
    victimDirty = wayValid[victimWay] && wayDirty[victimWay];
    memAddr     = stb.wbSel ? {wayTag[victimWay], selSet} : {selTag, selSet};
    memWData    = wayData[victimWay];
  end

  // recency: point at the way not touched by this hit or fill
  always_ff @(posedge clk) begin
    if (rst) begin
      lruQ <= '0;
    end else if (stb.hitUpd) begin
      lruQ[selSet] <= ~hitWay;
    end else if (stb.fill) begin
      lruQ[selSet] <= ~victimWay;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respData <= '0;
    end else if (stb.hitUpd) begin
      respData <= effWrite ? effWData : hitBlk[selOff*BYTE_W +: BYTE_W];
    end else if (stb.fill) begin
      respData <= curWrite ? curWData : memRData[selOff*BYTE_W +: BYTE_W];
    end
  end

  // R2
  hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitVec));

  // R4
  lru_flip_chk: assert property (@(posedge clk) disable iff (rst)
    stb.hitUpd |=> lruQ[$past(selSet)] != $past(hitWay));

  // R5
  victim_free_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.fill && !(wayValid[0] && wayValid[1])) |-> !wayValid[victimWay]);

  // R8
  write_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.hitUpd && effWrite) |=> respData == $past(effWData));

endmodule

// File: rtl/tw_cache_ctrl.sv
module tw_cache_ctrl
  import tw_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       lookupHit,
  input  logic       victimDirty,
  input  logic       memAck,
  output ctlStrobe_t stb,
  output logic       ready,
  output logic       respValid,
  output logic       memReq,
  output logic       memWrite
);

  ctlState_t stateQ, stateNext;
  logic      accept;

  always_comb begin
    accept    = (stateQ == ST_IDLE) && reqValid;
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (accept && !lookupHit) stateNext = victimDirty ? ST_WBACK : ST_REFILL;
      ST_WBACK:  if (memAck) stateNext = ST_REFILL;
      ST_REFILL: if (memAck) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.lookup = (stateQ == ST_IDLE);
    stb.latch  = accept;
    stb.hitUpd = accept && lookupHit;
    stb.fill   = (stateQ == ST_REFILL) && memAck;
    stb.wbSel  = (stateQ == ST_WBACK);
    ready      = (stateQ == ST_IDLE);
    memReq     = (stateQ == ST_WBACK) || (stateQ == ST_REFILL);
    memWrite   = (stateQ == ST_WBACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= ST_IDLE;
      respValid <= 1'b0;
    end else begin
      stateQ    <= stateNext;
      respValid <= stb.hitUpd || stb.fill;
    end
  end

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && memWrite && memAck) |=> (memReq && !memWrite));

  // R7
  clean_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && reqValid && !lookupHit && !victimDirty) |=> (memReq && !memWrite));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !ready);

endmodule

// File: rtl/tw_cache_top.sv
module tw_cache_top
  import tw_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 9,
  parameter int OFF_W  = 3,
  parameter int BYTE_W = 8,
  localparam int BLK_W  = BYTE_W << OFF_W,
  localparam int BADR_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0] reqWData,
  output logic              ready,
  output logic              respValid,
  output logic [BYTE_W-1:0] respData,
  output logic              memReq,
  output logic              memWrite,
  output logic [BADR_W-1:0] memAddr,
  output logic [BLK_W-1:0]  memWData,
  input  logic              memAck,
  input  logic [BLK_W-1:0]  memRData
);

  ctlStrobe_t stb;
  logic       lookupHit;
  logic       victimDirty;

  tw_cache_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .lookupHit  (lookupHit),
    .victimDirty(victimDirty),
    .memAck     (memAck),
    .stb        (stb),
    .ready      (ready),
    .respValid  (respValid),
    .memReq     (memReq),
    .memWrite   (memWrite)
  );

  tw_cache_dpath #(
    .ADDR_W(ADDR_W),
    .SET_W (SET_W),
    .OFF_W (OFF_W),
    .BYTE_W(BYTE_W)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqWData   (reqWData),
    .memRData   (memRData),
    .lookupHit  (lookupHit),
    .victimDirty(victimDirty),
    .respData   (respData),
    .memAddr    (memAddr),
    .memWData   (memWData)
  );

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

endmodule

// File: tb/tw_cache_top_test.sv
module tw_cache_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;
  localparam logic [31:0] NOISE_ADDR = {20'h00007, 9'd300, 3'd5};

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, reqWrite;
  logic [31:0] reqAddr;
  logic [7:0]  reqWData;
  logic        ready, respValid;
  logic [7:0]  respData;
  logic        memReq, memWrite;
  logic [28:0] memAddr;
  logic [63:0] memWData;
  logic        memAck;
  logic [63:0] memRData;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_cache_top uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .ready(ready),
    .respValid(respValid), .respData(respData), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memRData(memRData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // backing memory and architectural byte view
  logic [63:0] memStore [logic [28:0]];
  logic [7:0]  shadow   [logic [31:0]];

  function automatic logic [63:0] patBlk(input logic [28:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = 8'((int'(a[7:0]) * 7) + (i * 13) + 'h5A);
    return r;
  endfunction

  function automatic logic [63:0] memBlk(input logic [28:0] a);
    if (memStore.exists(a)) return memStore[a];
    return patBlk(a);
  endfunction

  function automatic logic [7:0] archByte(input logic [31:0] a);
    logic [63:0] b;
    if (shadow.exists(a)) return shadow[a];
    b = memBlk(a[31:3]);
    return b[int'(a[2:0])*8 +: 8];
  endfunction

  int          memCnt = 0;
  int          rdCnt  = 0;
  int          wbCnt  = 0;
  logic [28:0] lastWb = '0;
  logic [28:0] lastRd = '0;

  always @(negedge clk) begin
    if (rst) begin
      memAck = 1'b0;
      memCnt = 0;
    end else if (memAck) begin
      memAck = 1'b0;
      memCnt = 0;
    end else if (memReq) begin
      if (memCnt == MEM_LAT - 1) begin
        memCnt = 0;
        memAck = 1'b1;
        if (memWrite) begin
          for (int i = 0; i < 8; i++)
            chk("R6 written-back byte", memWData[i*8 +: 8], archByte({memAddr, 3'(i)}));
          memStore[memAddr] = memWData;
          wbCnt++;
          lastWb = memAddr;
        end else begin
          memRData = memBlk(memAddr);
          rdCnt++;
          lastRd = memAddr;
        end
      end else begin
        memCnt++;
      end
    end
  end

  // requirement-level model of tags, valid, modified and recency bits
  bit          mV [512][2];
  bit          mD [512][2];
  bit          mL [512];
  logic [19:0] mT [512][2];

  task automatic clearModel();
    for (int s = 0; s < 512; s++) begin
      mL[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        mV[s][w] = 1'b0;
        mD[s][w] = 1'b0;
        mT[s][w] = '0;
      end
    end
  endtask

  task automatic access(input bit wr, input logic [19:0] tg, input int st, input int off,
                        input logic [7:0] d, input string tagName, input bit noise = 1'b0);
    logic [31:0] addr;
    logic [28:0] expWbAddr;
    logic [7:0]  expData;
    int hw, expLat, expWbN, expRdN, lat, r0, w0;
    bit vw;
    addr = {tg, 9'(st), 3'(off)};
    hw = -1;
    expWbAddr = '0;
    for (int w = 0; w < 2; w++) if (mV[st][w] && mT[st][w] == tg) hw = w;
    if (hw >= 0) begin
      expLat = 1; expWbN = 0; expRdN = 0;
      mL[st] = ~1'(hw);
      if (wr) mD[st][hw] = 1'b1;
    end else begin
      if (!mV[st][0])      vw = 1'b0;
      else if (!mV[st][1]) vw = 1'b1;
      else                 vw = mL[st];
      expWbN = (mV[st][vw] && mD[st][vw]) ? 1 : 0;
      expWbAddr = {mT[st][vw], 9'(st)};
      expRdN = 1;
      expLat = (expWbN != 0) ? 8 : 4;
      mV[st][vw] = 1'b1; mT[st][vw] = tg; mD[st][vw] = wr; mL[st] = ~vw;
    end
    expData = wr ? d : archByte(addr);
    r0 = rdCnt; w0 = wbCnt;
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWData = d;
    @(negedge clk);
    lat = 1;
    if (noise) begin
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = NOISE_ADDR; reqWData = 8'hEE;
    end else begin
      reqValid = 1'b0;
    end
    while (!respValid && lat < 20) begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
    end
    chk({tagName, " answer latency"}, 64'(lat), 64'(expLat));
    chk({tagName, " response byte"}, 64'(respData), 64'(expData));
    chk({tagName, " write-back count"}, 64'(wbCnt - w0), 64'(expWbN));
    chk({tagName, " refill count"}, 64'(rdCnt - r0), 64'(expRdN));
    if (expWbN != 0) chk("R5 victim block address", 64'(lastWb), 64'(expWbAddr));
    if (expRdN != 0) chk("R1 refill block address", 64'(lastRd), 64'(addr[31:3]));
    if (wr) shadow[addr] = d;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWData = '0;
    memAck = 1'b0; memRData = '0;
    clearModel();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state at the ports
    chk("R9 ready after reset", 64'(ready), 64'd1);
    chk("R9 respValid after reset", 64'(respValid), 64'd0);
    chk("R9 memReq after reset", 64'(memReq), 64'd0);

    for (int s = 0; s < 8; s++) begin
      logic [19:0] tA, tB, tC;
      tA = 20'(s + 1);
      tB = 20'(s + 'h100);
      tC = 20'(s + 'h8000);
      access(1'b0, tA, s, s, 8'h00, "R9");            // cold miss, way 0
      access(1'b1, tB, s, (s + 3) % 8, 8'h30 + 8'(s), "R8"); // write-allocate, way 1
      access(1'b0, tA, s, (s + 5) % 8, 8'h00, "R2");  // hit
      for (int o = 0; o < 8; o++) access(1'b0, tA, s, o, 8'h00, "R3");
      access(1'b0, tC, s, s, 8'h00, "R4");            // evicts modified B
      access(1'b0, tB, s, (s + 3) % 8, 8'h00, "R6");  // written byte back from memory
      access(1'b1, tC, s, 1, 8'hC0 + 8'(s), "R8");    // write hit
      access(1'b0, tA, s, 2, 8'h00, "R5");            // evicts clean B
      access(1'b0, tB, s, 0, 8'h00, "R6");            // evicts modified C
      access(1'b0, tC, s, 1, 8'h00, "R7");            // read back C's write
    end

    // top set, extreme tags
    access(1'b1, 20'hFFFFF, 511, 7, 8'hA5, "R1");
    access(1'b0, 20'h00000, 511, 0, 8'h00, "R1");
    access(1'b0, 20'h00001, 511, 3, 8'h00, "R1");
    access(1'b0, 20'hFFFFF, 511, 7, 8'h00, "R1");

    // requests during a miss are ignored
    access(1'b0, 20'h00044, 300, 0, 8'h00, "R10", 1'b1);
    access(1'b0, 20'h00007, 300, 5, 8'h00, "R10");

    // mid-run reset drops every line
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clearModel();
    shadow.delete();
    @(negedge clk);
    chk("R9 ready after second reset", 64'(ready), 64'd1);
    chk("R9 memReq after second reset", 64'(memReq), 64'd0);
    access(1'b0, 20'h08000, 0, 1, 8'h00, "R9");
    access(1'b0, 20'h00001, 0, 2, 8'h00, "R9");

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule